// File: doc/BRIEF.md
# Oversampled SPI Mode-0 Slave

This block is an SPI slave for mode 0. It runs entirely on the system clock. The serial clock, chip select and MOSI lines are treated as ordinary data inputs. Each one passes through a two-flop synchroniser, and a further register stage detects edges on the serial clock and on chip select. Because edges are found by sampling, the serial clock must run at no more than half the system clock rate. In practice a margin of several system clocks per serial half-period is expected, so that MISO settles before the master samples it.

Each selection moves one 8-bit word in each direction, most significant bit first.
- When chip select falls, `xfer_begin` pulses for one cycle. In that same cycle `tx_word` is copied into the transmit shifter. The parent logic must therefore present the outgoing byte before selecting, or at the latest during that pulse.
- After the eighth rising edge of the serial clock, the received byte appears on `rx_word` and `xfer_end` pulses for one cycle. `rx_word` is valid only from that point.
- The slave never starts a transfer. To read a byte, the master clocks out a dummy byte.

Top module: `spi_m0_slave`

## Requirements
- R1: During and after reset, with chip select high, `miso` is 0, `rx_word` is 0x00, and `xfer_begin` and `xfer_end` are 0.
- R2: Each falling edge of `cs_n` produces exactly one `xfer_begin` pulse, one cycle wide. No pulse is produced at any other time.
- R3: MOSI is sampled on the rising edges of `sclk`, MSB first. After eight rising edges, `rx_word` holds the eight sampled bits, with the first bit in bit 7.
- R4: While selected, `miso` shows the transmit word MSB first. Bit 7 is present before the first rising edge of `sclk`, and each later bit follows a falling edge.
- R5: The transmit word is captured only in the cycle of `xfer_begin`. Changes to `tx_word` during the byte do not alter the bits sent on `miso`.
- R6: `xfer_end` pulses for one cycle after the eighth rising edge of `sclk`. `rx_word` changes only in that same cycle, and otherwise holds its value.
- R7: If `cs_n` rises before the eighth rising edge, no `xfer_end` pulse is produced and `rx_word` keeps its previous value.
- R8: Rising edges of `sclk` after the eighth, within the same selection, are ignored. They produce no further `xfer_end`, and `rx_word` does not change.
- R9: While `cs_n` is high, `miso` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master; idles low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| tx_word | input | WORD_W | Byte to send, captured on `xfer_begin` |
| rx_word | output | WORD_W | Last complete byte received |
| xfer_begin | output | 1 | One-cycle pulse when the slave is selected |
| xfer_end | output | 1 | One-cycle pulse when a byte is complete |

## Verification
The assertions check the following on every cycle:
- both strobes are single-cycle pulses;
- `xfer_begin` appears only after `cs_n` has been low at the synchroniser input;
- `xfer_end` appears only after a selected period;
- `rx_word` moves only together with `xfer_end`;
- `miso` stays low once chip select has been high for several cycles.

The bench scenarios show what no single-cycle property can:
- the bit order on both data lines;
- that the transmit word is frozen at the begin strobe;
- that aborted bytes and surplus clock edges leave `rx_word` untouched.

// File: rtl/spi_m0_slave.sv
module spi_m0_slave #(
  parameter int WORD_W   = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              xfer_begin,
  output logic              xfer_end
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic [SYNC_LEN:0]   sclk_p, cs_p;
  logic [SYNC_LEN-1:0] mosi_p;
  logic [CNT_W-1:0]    bit_cnt;
  logic [WORD_W-1:0]   tx_sh, rx_sh;
  logic                miso_q, end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC_LEN-1:0], sclk};
      cs_p   <= {cs_p[SYNC_LEN-1:0], cs_n};
      mosi_p <= {mosi_p[SYNC_LEN-2:0], mosi};
    end
  end

  wire sclk_s = sclk_p[SYNC_LEN-1];
  wire sclk_d = sclk_p[SYNC_LEN];
  wire cs_s   = cs_p[SYNC_LEN-1];
  wire cs_d   = cs_p[SYNC_LEN];
  wire mosi_s = mosi_p[SYNC_LEN-1];

  wire sel     = !cs_s;
  wire cs_fall = !cs_s && cs_d;
  wire full    = (bit_cnt == FULL_CNT);
  wire s_rise  = sel && sclk_s && !sclk_d && !full;
  wire s_fall  = sel && !sclk_s && sclk_d;
  wire last    = s_rise && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              bit_cnt <= '0;
    else if (cs_fall || !sel) bit_cnt <= '0;
    else if (s_rise)         bit_cnt <= bit_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_sh <= '0;
    else if (cs_fall) tx_sh <= tx_word;
    else if (s_fall)  tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miso_q <= 1'b0;
    else        miso_q <= sel && !cs_fall && tx_sh[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh   <= '0;
      rx_word <= '0;
      end_q   <= 1'b0;
    end else begin
      end_q <= last;
      if (s_rise) rx_sh   <= {rx_sh[WORD_W-2:0], mosi_s};
      if (last)   rx_word <= {rx_sh[WORD_W-2:0], mosi_s};
    end
  end

  assign miso       = miso_q;
  assign xfer_end   = end_q;
  assign xfer_begin = cs_fall;

endmodule

// File: rtl/spi_m0_slave_chk.sv
module spi_m0_slave_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              miso,
  input logic [WORD_W-1:0] rx_word,
  input logic              xfer_begin,
  input logic              xfer_end
);

  // R2
  begin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_begin |=> !xfer_begin);

  // R2
  begin_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_begin |-> !$past(cs_n, 2));

  // R6
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !xfer_end);

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> xfer_end);

  // R7
  end_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> !$past(cs_n, 3));

  // R9
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);

endmodule

bind spi_m0_slave spi_m0_slave_chk #(.WORD_W(WORD_W)) chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .rx_word(rx_word),
  .xfer_begin(xfer_begin), .xfer_end(xfer_end)
);

// File: tb/tb_spi_m0_slave.sv
`timescale 1ns/1ps
module tb_spi_m0_slave;

  localparam int HP = 8;
  localparam logic [15:0] VECS [6] = '{
    16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h81_7E, 16'h5A_C3, 16'h01_80
  };

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic [7:0] tx_word = 8'h00;
  logic miso, xfer_begin, xfer_end;
  logic [7:0] rx_word;
  int errors = 0, checks = 0, n_begin = 0, n_end = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  spi_m0_slave dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .tx_word(tx_word), .rx_word(rx_word),
    .xfer_begin(xfer_begin), .xfer_end(xfer_end)
  );

  always @(posedge clk) begin
    if (rst_n && xfer_begin) n_begin <= n_begin + 1;
    if (rst_n && xfer_end)   n_end   <= n_end + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] mo, input int nbits, input bit flip_tx,
                      output logic [7:0] mi);
    mi = '0;
    @(negedge clk);
    cs_n = 0;
    wait_clk(HP);
    if (flip_tx) tx_word = ~tx_word;
    for (int b = 0; b < nbits; b++) begin
      mosi = (b < 8) ? mo[7-b] : 1'b1;
      wait_clk(HP);
      if (b < 8) mi[7-b] = miso;
      sclk = 1;
      wait_clk(HP);
      sclk = 0;
    end
    wait_clk(HP);
    cs_n = 1;
    wait_clk(2 * HP);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_clk(3);
    // R1
    check("R1 miso", miso, 0);
    check("R1 rx_word", rx_word, 0);
    check("R1 strobes", {xfer_begin, xfer_end}, 0);
    rst_n = 1;
    wait_clk(5);
    check("R1 post-reset", {miso, xfer_begin, xfer_end, rx_word}, 0);

    for (int v = 0; v < 6; v++) begin
      int b0, e0;
      b0 = n_begin; e0 = n_end;
      tx_word = VECS[v][7:0];
      xfer(VECS[v][15:8], 8, 1'b0, got);
      check("R3 rx_word", rx_word, VECS[v][15:8]);
      check("R4 miso byte", got, VECS[v][7:0]);
      check("R2 one begin", n_begin - b0, 1);
      check("R6 one end", n_end - e0, 1);
    end

    begin
      int b0, e0;
      // R5: tx_word changed after begin must not affect MISO
      b0 = n_begin; e0 = n_end;
      tx_word = 8'hB4;
      xfer(8'h6D, 8, 1'b1, got);
      check("R5 tx frozen", got, 8'hB4);
      check("R3 rx_word", rx_word, 8'h6D);

      // R7: abort after 4 bits
      e0 = n_end;
      xfer(8'hFF, 4, 1'b0, got);
      check("R7 no end", n_end - e0, 0);
      check("R7 rx kept", rx_word, 8'h6D);

      // R8: ten edges in one selection
      e0 = n_end; b0 = n_begin;
      tx_word = 8'h00;
      xfer(8'h93, 10, 1'b0, got);
      check("R8 single end", n_end - e0, 1);
      check("R8 rx first byte", rx_word, 8'h93);
      check("R2 begin per select", n_begin - b0, 1);

      // R9: deselected MISO low even with tx all ones
      tx_word = 8'hFF;
      wait_clk(20);
      check("R9 miso idle", miso, 0);
      check("R2 no begin idle", n_begin - b0, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule